// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of several requester localities owns a shared security coprocessor at any moment. Every locality has its own byte-wide access register. All of them are reached through one register bus, and every access on that bus carries a locality tag. A write to the register of a locality acts on behalf of that locality. A read returns that locality's view of the ownership state.

A locality asks for the device by raising a request. The device is granted at once when nobody holds it. When the owner gives it up, it passes to the highest locality that is still waiting. A locality with a higher number than the current owner can take the device by force. The owner that lost it then keeps a sticky flag that records the loss, until that locality clears the flag itself.

The block also holds a platform flag that shows whether a trusted environment has been established. A platform pulse establishes it. Only writes from the two highest localities can set it back to the not-established state.

Top module: `acc_arbiter`

## Requirements
- R1: For a legal locality (0 to 4), a read returns an access byte with bit 7 = 1 (valid), and bit 6 and bit 3 always read 0.
- R2: Bit 5 (active) reads 1 only in the register of the current owner. At most one locality is active. The outputs `owner_valid`/`owner_loc` name that owner.
- R3: Writing 1 to bit 1 (request) while no locality owns the device grants ownership to the writer at the same clock edge. While another locality owns it, the request is held, and the owner's own request bit is ignored.
- R4: Bit 1 reads 1 while that locality's request is outstanding. Bit 2 (pending) reads 1 when any other locality has an outstanding request.
- R5: When the owner writes 1 to bit 5, it gives up ownership. At the same edge the device passes to the highest-numbered outstanding requester, or becomes unowned if there is none. When a non-owner writes 1 to bit 5, it withdraws its own request.
- R6: Writing 1 to bit 3 (seize) from a locality numbered higher than the owner, or while the device is unowned, makes the writer the owner and clears the writer's request. The former owner gets bit 4 (seized) set.
- R7: A seize from a locality that is not numbered higher than the current owner leaves ownership and all flags unchanged.
- R8: Bit 4 stays 1 until its own locality writes 1 to bit 4.
- R9: Bit 0 reads 1 from reset while no trusted environment is established. A pulse on `env_establish` clears it. A write of 1 to bit 0 sets it again only from locality 3 or 4, and that write wins over a pulse in the same cycle. The same write from localities 0 to 2 is ignored.
- R10: Accesses tagged with locality 5 to 7 change nothing, and reads with those tags return 8'h00.
- R11: Read data appears with `rd_valid` one cycle after the read access. It shows the state left by all earlier writes.
- R12: After reset no locality owns the device and every legal register reads 8'h81.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_loc | input | 3 | Locality tag of the access |
| bus_wdata | input | 8 | Write data for the access register |
| env_establish | input | 1 | Platform pulse that marks the trusted environment established |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 8 | Access register view of the tagged locality |
| owner_valid | output | 1 | Some locality owns the device |
| owner_loc | output | 3 | Owning locality, 0 when unowned |

## Verification
A write takes effect at the rising edge that samples it. `owner_valid` and `owner_loc` are therefore due one edge after the write. A register read issued in the following cycle returns its byte one edge after that read. The bench drives each access on a falling edge and holds it for exactly one cycle. It samples read data and owner outputs on the next falling edge, so every result is compared in the cycle it is due. Expected bytes come from a bench-side model of the requirements. Sweeps cover every owner/seizer pair and every set of waiting requesters for each owner.

// File: rtl/acc_arb_pkg.sv
package acc_arb_pkg;

    localparam int AB_EST_OPEN = 0;
    localparam int AB_REQUEST  = 1;
    localparam int AB_PENDING  = 2;
    localparam int AB_SEIZE    = 3;
    localparam int AB_SEIZED   = 4;
    localparam int AB_ACTIVE   = 5;
    localparam int AB_VALID    = 7;

    typedef struct packed {
        logic clr_seized;
        logic est_reopen;
        logic drop;
        logic seize;
        logic request;
    } acc_cmd_t;

    function automatic acc_cmd_t decode_cmd(input logic [7:0] d);
        acc_cmd_t c;
        c.clr_seized = d[AB_SEIZED];
        c.est_reopen = d[AB_EST_OPEN];
        c.drop       = d[AB_ACTIVE];
        c.seize      = d[AB_SEIZE];
        c.request    = d[AB_REQUEST];
        return c;
    endfunction

    function automatic logic [7:0] make_view(input logic active, input logic seized,
                                             input logic pending, input logic req,
                                             input logic est_open);
        logic [7:0] v;
        v              = '0;
        v[AB_VALID]    = 1'b1;
        v[AB_ACTIVE]   = active;
        v[AB_SEIZED]   = seized;
        v[AB_PENDING]  = pending;
        v[AB_REQUEST]  = req;
        v[AB_EST_OPEN] = est_open;
        return v;
    endfunction

endpackage

// File: rtl/acc_slot.sv
module acc_slot
    import acc_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  acc_cmd_t cmd,
    input  logic     active,
    input  logic     grant,
    input  logic     lose,
    output logic     req_q,
    output logic     req_eff,
    output logic     seized_q
);

    // request after this cycle's write, before any grant
    assign req_eff = (req_q & ~cmd.drop) | (cmd.request & ~active);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= 1'b0;
            seized_q <= 1'b0;
        end else begin
            req_q <= grant ? 1'b0 : req_eff;
            if (lose)
                seized_q <= 1'b1;
            else if (cmd.clr_seized)
                seized_q <= 1'b0;
        end
    end

    assert_seized_on_loss_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(seized_q) |-> ($past(active) && !active));

    assert_grant_clears_req_R3: assert property (@(posedge clk) disable iff (rst)
        grant |=> !req_q);

    assert_seized_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (seized_q && !cmd.clr_seized) |=> seized_q);

endmodule

// File: rtl/acc_owner.sv
module acc_owner
    import acc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_ok,
    input  logic [LOC_W-1:0]   wr_loc,
    input  acc_cmd_t           cmd,
    input  logic [NUM_LOC-1:0] req_eff,
    output logic               owner_vld,
    output logic [LOC_W-1:0]   owner_q,
    output logic [NUM_LOC-1:0] grant,
    output logic [NUM_LOC-1:0] lose
);

    logic             relq, vld_a, seize_ok, hi_found, nv;
    logic [LOC_W-1:0] hi_idx, nxt;

    assign relq     = wr_ok && cmd.drop && owner_vld && (wr_loc == owner_q);
    assign vld_a    = owner_vld && !relq;
    assign seize_ok = wr_ok && cmd.seize && (!vld_a || (wr_loc > owner_q));

    // highest-numbered outstanding requester
    always_comb begin
        hi_found = 1'b0;
        hi_idx   = '0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (req_eff[i]) begin
                hi_found = 1'b1;
                hi_idx   = LOC_W'(i);
            end
        end
    end

    always_comb begin
        grant = '0;
        lose  = '0;
        nv    = vld_a;
        nxt   = vld_a ? owner_q : '0;
        if (seize_ok) begin
            nv            = 1'b1;
            nxt           = wr_loc;
            grant[wr_loc] = 1'b1;
            if (vld_a)
                lose[owner_q] = 1'b1;
        end else if (!vld_a && hi_found) begin
            nv            = 1'b1;
            nxt           = hi_idx;
            grant[hi_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_vld <= 1'b0;
            owner_q   <= '0;
        end else begin
            owner_vld <= nv;
            owner_q   <= nxt;
        end
    end

    assert_low_seize_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && cmd.seize && owner_vld && !cmd.drop && (wr_loc <= owner_q))
        |=> (owner_vld && (owner_q == $past(owner_q))));

    assert_release_to_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (relq && !cmd.seize && !(|req_eff)) |=> !owner_vld);

    assert_one_grant_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

endmodule

// File: rtl/acc_est_flag.sv
module acc_est_flag (
    input  logic clk,
    input  logic rst,
    input  logic reopen,
    input  logic establish,
    output logic open_q
);

    always_ff @(posedge clk) begin
        if (rst)
            open_q <= 1'b1;
        else if (reopen)
            open_q <= 1'b1;
        else if (establish)
            open_q <= 1'b0;
    end

    assert_establish_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (establish && !reopen) |=> !open_q);

endmodule

// File: rtl/acc_arbiter.sv
module acc_arbiter
    import acc_arb_pkg::*;
#(
    parameter int NUM_LOC     = 5,
    parameter int EST_MIN_LOC = 3,
    localparam int LOC_W      = $clog2(NUM_LOC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [LOC_W-1:0] bus_loc,
    input  logic [7:0]       bus_wdata,
    input  logic             env_establish,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             owner_valid,
    output logic [LOC_W-1:0] owner_loc
);

    logic               in_range, wr_ok, rd_req, est_reopen, est_open;
    acc_cmd_t           cmd_all;
    acc_cmd_t           cmd_loc [NUM_LOC];
    logic [NUM_LOC-1:0] req_q, req_eff, seized_q, active, grant, lose;
    logic [7:0]         view [NUM_LOC];
    logic               unused_wbits;

    assign unused_wbits = ^{bus_wdata[6], bus_wdata[2], bus_wdata[7]};
    assign in_range     = int'(bus_loc) < NUM_LOC;
    assign wr_ok        = bus_valid && bus_write && in_range;
    assign rd_req       = bus_valid && !bus_write;
    assign cmd_all      = decode_cmd(bus_wdata);
    assign est_reopen   = wr_ok && cmd_all.est_reopen && (int'(bus_loc) >= EST_MIN_LOC);

    for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
        assign cmd_loc[i] = (wr_ok && (bus_loc == LOC_W'(i))) ? cmd_all : '0;
        assign active[i]  = owner_valid && (owner_loc == LOC_W'(i));

        acc_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .cmd      (cmd_loc[i]),
            .active   (active[i]),
            .grant    (grant[i]),
            .lose     (lose[i]),
            .req_q    (req_q[i]),
            .req_eff  (req_eff[i]),
            .seized_q (seized_q[i])
        );

        assign view[i] = make_view(active[i], seized_q[i],
                                   |(req_q & ~(NUM_LOC'(1) << i)),
                                   req_q[i], est_open);
    end

    acc_owner #(
        .NUM_LOC (NUM_LOC),
        .LOC_W   (LOC_W)
    ) u_owner (
        .clk       (clk),
        .rst       (rst),
        .wr_ok     (wr_ok),
        .wr_loc    (bus_loc),
        .cmd       (cmd_all),
        .req_eff   (req_eff),
        .owner_vld (owner_valid),
        .owner_q   (owner_loc),
        .grant     (grant),
        .lose      (lose)
    );

    acc_est_flag u_est (
        .clk       (clk),
        .rst       (rst),
        .reopen    (est_reopen),
        .establish (env_establish),
        .open_q    (est_open)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req)
                rd_data <= in_range ? view[bus_loc] : 8'h00;
        end
    end

    assert_single_owner_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(active));

    assert_owner_holds_no_req_R3: assert property (@(posedge clk) disable iff (rst)
        owner_valid |-> ((req_q & active) == '0));

    assert_read_valid_bit_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_req && in_range) |=> (rd_valid && rd_data[AB_VALID] && !rd_data[6] && !rd_data[AB_SEIZE]));

    assert_bad_loc_read_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !in_range) |=> (rd_valid && (rd_data == 8'h00)));

    assert_reopen_source_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(est_open) |-> $past(bus_valid && bus_write && bus_wdata[AB_EST_OPEN]
                                  && (int'(bus_loc) >= EST_MIN_LOC) && in_range));

endmodule

// File: tb/acc_arbiter_test.sv
`timescale 1ns/1ps
module acc_arbiter_test;

    localparam int NL = 5;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_valid, bus_write, env_establish;
    logic [2:0] bus_loc;
    logic [7:0] bus_wdata;
    logic       rd_valid, owner_valid;
    logic [7:0] rd_data;
    logic [2:0] owner_loc;

    int  n_cmp  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    // requirement model
    bit  mr [NL];
    bit  ms [NL];
    bit  mv;
    int  mo;
    bit  mest;

    always #2.5 clk = ~clk;

    acc_arbiter uut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_loc(bus_loc), .bus_wdata(bus_wdata), .env_establish(env_establish),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .owner_valid(owner_valid), .owner_loc(owner_loc)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_view(input int l);
        logic [7:0] v;
        bit pend;
        if (l >= NL) return 8'h00;
        pend = 0;
        for (int j = 0; j < NL; j++) if (j != l && mr[j]) pend = 1;
        v = 8'h80;
        v[5] = mv && (mo == l);
        v[4] = ms[l];
        v[2] = pend;
        v[1] = mr[l];
        v[0] = mest;
        return v;
    endfunction

    task automatic model_write(input int l, input logic [7:0] d);
        bit act;
        if (l >= NL) return;
        act = mv && (mo == l);
        if (d[4]) ms[l] = 0;
        if (d[0] && l >= 3) mest = 1;
        if (d[5]) begin
            if (act) mv = 0;
            mr[l] = 0;
        end
        if (d[3] && (!mv || l > mo)) begin
            if (mv) ms[mo] = 1;
            mv = 1; mo = l; mr[l] = 0;
        end else if (d[1] && !act) begin
            mr[l] = 1;
        end
        if (!mv) begin
            for (int j = 0; j < NL; j++) if (mr[j]) begin mo = j; mv = 1; end
            if (mv) mr[mo] = 0;
        end
    endtask

    // entered and left on a falling edge
    task automatic wr(input int l, input logic [7:0] d);
        bus_valid = 1; bus_write = 1; bus_loc = 3'(l); bus_wdata = d;
        model_write(l, d);
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input int l, input string tag);
        bus_valid = 1; bus_write = 0; bus_loc = 3'(l);
        @(negedge clk);
        bus_valid = 0;
        check({tag, " rd_valid (R11)"}, int'(rd_valid), 1);
        check({tag, " byte"}, int'(rd_data), int'(exp_view(l)));
        check({tag, " owner_valid (R2)"}, int'(owner_valid), int'(mv));
        if (mv) check({tag, " owner_loc (R2)"}, int'(owner_loc), mo);
    endtask

    task automatic rd_all(input string tag);
        for (int l = 0; l < NL; l++) rd(l, tag);
    endtask

    task automatic clear_all();
        for (int l = 0; l < NL; l++) wr(l, 8'h30);
    endtask

    task automatic pulse_establish(input logic [7:0] d, input int l, input bit with_wr);
        env_establish = 1;
        if (with_wr) wr(l, d);
        else begin
            mest = 0;
            @(negedge clk);
        end
        env_establish = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; bus_valid = 0; bus_write = 0; bus_loc = 0; bus_wdata = 0; env_establish = 0;
        for (int l = 0; l < NL; l++) begin mr[l] = 0; ms[l] = 0; end
        mv = 0; mo = 0; mest = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R12: reset state, every register 8'h81
        check("R12 owner_valid after reset", int'(owner_valid), 0);
        for (int l = 0; l < NL; l++) begin
            rd(l, "R12 reset");
            check("R12 reset byte", int'(rd_data), 8'h81);
        end

        // R10: illegal locality tags ignored, reads return 0
        for (int l = NL; l < 8; l++) begin
            wr(l, 8'h0B);
            rd(l, "R10 bad tag read");
        end
        rd_all("R10 state untouched");

        // R3/R7/R6: owner/seizer sweep, R1 via full-byte comparisons
        for (int o = 0; o < NL; o++) begin
            for (int s = 0; s < NL; s++) begin
                clear_all();
                wr(o, 8'h02);
                rd(o, "R3 idle grant");
                wr(s, 8'h08);
                rd_all((s > o) ? "R6 seize by higher" : "R7 seize not higher");
                wr(s, 8'h02);
                rd_all("R8 seized kept / R3 held request");
                wr(o, 8'h10);
                rd(o, "R8 seized cleared by owner of flag");
            end
        end

        // R6: seize while unowned
        clear_all();
        wr(1, 8'h08);
        rd_all("R6 seize when unowned");

        // R4/R5: every set of waiting requesters for every owner
        for (int o = 0; o < NL; o++) begin
            for (int m = 0; m < 32; m++) begin
                clear_all();
                wr(o, 8'h02);
                for (int j = 0; j < NL; j++) if (m[j] && j != o) wr(j, 8'h02);
                wr(o, 8'h02);
                rd_all("R4 pending view");
                wr(o, 8'h20);
                rd_all("R5 handoff to highest");
            end
        end

        // R5: non-owner withdraws request
        clear_all();
        wr(0, 8'h02);
        wr(2, 8'h02);
        rd(1, "R4 pending seen");
        wr(2, 8'h20);
        rd(1, "R5 withdrawn request");
        rd(2, "R5 withdrawn request own");

        // R9: establish flag per locality
        for (int l = 0; l < NL; l++) begin
            pulse_establish(8'h00, 0, 0);
            rd(l, "R9 established");
            wr(l, 8'h01);
            rd(l, (l >= 3) ? "R9 reopen from high" : "R9 reopen ignored");
        end
        for (int l = 0; l < NL; l++) begin
            pulse_establish(8'h01, l, 1);
            if (l < 3) mest = 0;
            rd(l, "R9 same-cycle write vs pulse");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule